// File: doc/BRIEF.md
# Double-Buffered Serial DAC Register Front End

This block is the digital side of a 16-bit voltage-output converter. A host writes a code word over a three-wire serial link made of an active-low select, a serial clock and a data line. Bits go into a shift register. Each completed frame moves the shift register into an input register. A second register, the converter latch, drives the analog core. The latch is loaded either at the same moment as the input register or later, when a separate active-low load pin falls.

All four pins are oversampled by a faster system clock. Each pin passes through a synchroniser, and its edges are found in the system clock domain. The latch value goes to the converter core, together with a one-cycle strobe each time the latch is written. A protocol-error pulse reports a load request made in the middle of a frame.

Top module: `dac_serial_frontend`

## Requirements
- R1: While the select pin is high, edges on the serial clock and data on the data pin leave the shift register untouched.
- R2: With select low, each rising serial clock edge shifts the data bit into the LSB of a DATA_W-bit shift register, so the first bit sent ends up nearest the MSB. A frame longer than DATA_W bits keeps only the last DATA_W bits.
- R3: A rising edge on the select pin copies the shift register into the input register.
- R4: A frame of k < DATA_W bits yields (previous shift contents << k) | new bits; the shift register is not cleared between frames.
- R5: Reset clears the input register, the latch output, the update strobe and the error pulse to zero. The shift register is not reset.
- R6: With mode_immediate = 1, the latch takes the new word at the same clock edge as the input register, and the load pin has no effect.
- R7: With mode_immediate = 0 and the load pin high, a frame end leaves the latch unchanged. A later falling edge on the load pin, while select is high, copies the input register into the latch.
- R8: With mode_immediate = 0 and the load pin low at the moment select rises, the latch takes the new word at that frame end.
- R9: With mode_immediate = 0, a falling edge on the load pin while select is low raises proto_err for one cycle and does not change the latch.
- R10: dac_update is high for exactly one system cycle for each latch write and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low latch load request |
| mode_immediate | input | 1 | 1: latch follows each frame; 0: latch waits for the load pin |
| dac_code | output | DATA_W | Converter latch contents |
| dac_update | output | 1 | One-cycle pulse for each latch write |
| proto_err | output | 1 | One-cycle pulse when a load request arrives inside a frame |

## Verification
The bench builds the block with DATA_W = 16 and two synchroniser stages, so every word value can be reached. Frame lengths of 8, 12, 16 and 20 bits are mixed, which covers both the over-length case and the short-frame case that keeps old bits. Random frames alternate between immediate and load-controlled updates. Directed cases add a load pin held low, a load request inside a frame, and clock toggles while select is high.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int PIN_SEL  = 0;
  localparam int PIN_SCK  = 1;
  localparam int PIN_SDAT = 2;
  localparam int PIN_LOAD = 3;
  localparam int NUM_PINS = 4;
  // idle levels: select and load high, clock and data low
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1001;

  typedef struct packed {
    logic sel_high;
    logic sel_rise;
    logic sck_rise;
    logic sdat;
    logic load_high;
    logic load_fall;
  } pin_evt_t;
endpackage

// File: rtl/dfe_sync.sv
module dfe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= RST_VAL;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dfe_edge.sv
module dfe_edge
  import dac_fe_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] lvl,
  output pin_evt_t            evt
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= PIN_IDLE;
    else     prev_q <= lvl;
  end

  always_comb begin
    evt.sel_high  = lvl[PIN_SEL];
    evt.sel_rise  = lvl[PIN_SEL] & ~prev_q[PIN_SEL];
    evt.sck_rise  = lvl[PIN_SCK] & ~prev_q[PIN_SCK];
    evt.sdat      = lvl[PIN_SDAT];
    evt.load_high = lvl[PIN_LOAD];
    evt.load_fall = ~lvl[PIN_LOAD] & prev_q[PIN_LOAD];
  end
endmodule

// File: rtl/dfe_shift.sv
module dfe_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_high,
  input  logic              sck_rise,
  input  logic              sdat,
  output logic [DATA_W-1:0] word
);
  logic [DATA_W-1:0] sr_q;

  // no reset on purpose: contents survive across frames
  always_ff @(posedge clk) begin
    if (!sel_high && sck_rise) sr_q <= {sr_q[DATA_W-2:0], sdat};
  end

  assign word = sr_q;

  AST_SHIFT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    sel_high |=> $stable(sr_q)); // R1
  AST_SHIFT_LSB_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!sel_high && sck_rise) |=> (sr_q[0] == $past(sdat))); // R2
endmodule

// File: rtl/dfe_latch.sv
module dfe_latch
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_immediate,
  input  pin_evt_t          evt,
  input  logic [DATA_W-1:0] shift_word,
  output logic [DATA_W-1:0] code,
  output logic              update,
  output logic              err
);
  logic [DATA_W-1:0] inreg_q;
  logic [DATA_W-1:0] load_val;
  logic              load_now;
  logic              err_now;

  always_comb begin
    load_now = 1'b0;
    err_now  = 1'b0;
    load_val = inreg_q;
    if (evt.sel_rise && (mode_immediate || !evt.load_high)) begin
      load_now = 1'b1;
      load_val = shift_word;
    end else if (!mode_immediate && evt.load_fall) begin
      if (evt.sel_high) load_now = 1'b1;
      else              err_now  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inreg_q <= '0;
      code    <= '0;
      update  <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (evt.sel_rise) inreg_q <= shift_word;
      if (load_now)     code    <= load_val;
      update <= load_now;
      err    <= err_now;
    end
  end

  AST_INREG_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    !evt.sel_rise |=> $stable(inreg_q)); // R3
  AST_CODE_CHANGE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code)) |-> update); // R10
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    err |-> (!update && $stable(code))); // R9
  AST_IMM_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (mode_immediate && evt.sel_rise) |=> (code == inreg_q)); // R6
endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
  import dac_fe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdata,
  input  logic              load_n,
  input  logic              mode_immediate,
  output logic [DATA_W-1:0] dac_code,
  output logic              dac_update,
  output logic              proto_err
);
  logic [NUM_PINS-1:0] raw_pins;
  logic [NUM_PINS-1:0] sync_pins;
  logic [DATA_W-1:0]   shift_word;
  pin_evt_t            evt;

  always_comb begin
    raw_pins           = '0;
    raw_pins[PIN_SEL]  = sel_n;
    raw_pins[PIN_SCK]  = sck;
    raw_pins[PIN_SDAT] = sdata;
    raw_pins[PIN_LOAD] = load_n;
  end

  dfe_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(sync_pins)
  );

  dfe_edge u_edge (
    .clk(clk), .rst(rst), .lvl(sync_pins), .evt(evt)
  );

  dfe_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .sel_high(evt.sel_high), .sck_rise(evt.sck_rise),
    .sdat(evt.sdat), .word(shift_word)
  );

  dfe_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .mode_immediate(mode_immediate), .evt(evt),
    .shift_word(shift_word), .code(dac_code), .update(dac_update), .err(proto_err)
  );

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dac_update |=> !dac_update); // R10
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err); // R9
endmodule

// File: tb/tb_dac_serial_frontend.sv
module tb_dac_serial_frontend;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sck = 1'b0, sdata = 1'b0, load_n = 1'b1, mode_immediate = 1'b1;
  logic [DW-1:0] dac_code;
  logic dac_update, proto_err;

  int total = 0, bad = 0;
  int upd_seen = 0, err_seen = 0, upd_exp = 0, err_exp = 0;
  bit done = 0;
  logic [DW-1:0] m_shift = '0, m_inreg = '0, m_code = '0;

  always #10 clk = ~clk;

  dac_serial_frontend #(.DATA_W(DW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .sdata(sdata), .load_n(load_n),
    .mode_immediate(mode_immediate), .dac_code(dac_code), .dac_update(dac_update),
    .proto_err(proto_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (dac_update) upd_seen++;
      if (proto_err)  err_seen++;
    end
  end

  function automatic logic [DW-1:0] shift_in(logic [DW-1:0] cur, logic b);
    return {cur[DW-2:0], b};
  endfunction

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_n(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic send(logic [31:0] w, int nbits, bit ld_glitch);
    sel_n = 1'b0;
    hold(4);
    if (ld_glitch) begin
      load_n = 1'b0; hold(6);
      if (!mode_immediate) err_exp++;
      load_n = 1'b1; hold(4);
    end
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = w[i]; sck = 1'b0; hold(3);
      sck = 1'b1; hold(3);
      m_shift = shift_in(m_shift, w[i]);
    end
    sck = 1'b0; hold(3);
    sel_n = 1'b1;
    m_inreg = m_shift;
    if (mode_immediate || !load_n) begin m_code = m_shift; upd_exp++; end
    hold(8);
  endtask

  task automatic set_load(logic v);
    if (!v && load_n && !mode_immediate && sel_n) begin m_code = m_inreg; upd_exp++; end
    load_n = v; hold(8);
  endtask

  task automatic load_pulse();
    set_load(1'b0);
    set_load(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    hold(5);
    rst = 1'b0;
    hold(2);
    chk("R5 reset code", dac_code, '0);
    chk("R5 reset strobe", {15'd0, dac_update}, '0);
    chk("R5 reset err", {15'd0, proto_err}, '0);

    // R6 immediate mode, full frame
    send(32'hA5C3, 16, 0);
    chk("R6 immediate word", dac_code, 16'hA5C3);
    // R2 over-length frame keeps last 16 bits
    send(32'hF_1234, 20, 0);
    chk("R2 long frame", dac_code, 16'h1234);
    // R1 clock activity with select high is ignored, then R4 short frame
    sdata = 1'b1;
    for (int i = 0; i < 5; i++) begin sck = 1'b1; hold(4); sck = 1'b0; hold(4); end
    send(32'h00CD, 8, 0);
    chk("R1 R4 idle clocks ignored, short frame", dac_code, 16'h34CD);
    // R6 load pin ignored in immediate mode
    load_pulse();
    chk("R6 load ignored immediate", dac_code, 16'h34CD);

    // R7 load-controlled mode
    mode_immediate = 1'b0; hold(2);
    send(32'h5A5A, 16, 0);
    chk("R7 held until load", dac_code, 16'h34CD);
    load_pulse();
    chk("R3 R7 load transfer", dac_code, 16'h5A5A);
    // R9 load request inside frame
    send(32'h0F0F, 16, 1);
    chk("R9 no write on error", dac_code, 16'h5A5A);
    chk_n("R9 error pulses", err_seen, err_exp);
    load_pulse();
    chk("R7 after error", dac_code, 16'h0F0F);
    // R8 load held low
    set_load(1'b0);
    send(32'hBEEF, 16, 0);
    chk("R8 held-low update", dac_code, 16'hBEEF);
    send(32'h0012, 12, 0);
    chk("R8 R4 short frame held-low", dac_code, m_code);
    set_load(1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int nb;
      logic [31:0] w;
      mode_immediate = $urandom_range(0, 1); hold(2);
      case ($urandom_range(0, 4))
        0: nb = 8; 1: nb = 12; 2: nb = 20; default: nb = 16;
      endcase
      w = $urandom;
      send(w, nb, ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 1)) load_pulse();
      chk("R2 R3 R7 random frame", dac_code, m_code);
    end

    chk_n("R10 strobe count", upd_seen, upd_exp);
    chk_n("R9 error count", err_seen, err_exp);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule